// File: doc/BRIEF.md
# Row-Aware Multi-Core DRAM Request Scheduler

This block sits between a set of processor cores and one shared DRAM. Each core pushes load and store requests into a buffer of its own. The scheduler then decides which buffered request goes to the DRAM next. It keeps serving the row that is already open, because a hit in the open row is far cheaper than opening a new one.

A run on one open row is limited to ROW_DELAY / COL_DELAY requests. When the run ends, the scheduler re-arbitrates. The first rotating search looks only at cores that raise a priority-load flag and still hold work. If that search finds nothing, a second rotating search over all cores with pending work decides. Both searches start at the core just after the one that was served last, so no core is favoured for good.

Inside a buffer, a newer load to the same destination register drops the older pending load. A newer store to the same address drops the older pending store, as long as no pending load to that address sits in the buffer. Only one DRAM request is outstanding at a time. A completed load is routed back to the core that issued it.

Top module: `rsched_top`

## Requirements
- R1: Each core buffer holds DEPTH entries. push_ready for a core is low exactly while its buffer is full, and a push offered while push_ready is low is discarded.
- R2: From idle, the scheduler chooses with the same rotating searches, starting at the core after the last one served. After reset the search starts at core 0. A core whose request lands alone is chosen directly.
- R3: While the head request of the current core lies in the open row (row = address bits above the low COL_W bits), the scheduler keeps issuing from that core.
- R4: At most MAX_RUN = ROW_DELAY / COL_DELAY requests are issued between two arbitrations. When the cap is reached, a new arbitration is made, and it may select the same core again.
- R5: Re-arbitration first picks, by rotating search from the core after the current one, a core that has its prio bit set and a non-empty buffer. Only if there is none does it pick the next non-empty core in the same rotating order.
- R6: When the head of the current core lies in a different row, the scheduler re-arbitrates instead of issuing that request.
- R7: A request is issued when mem_valid and mem_ready are both high. Exactly one request is outstanding, and mem_valid stays low from the issue until mem_done.
- R8: mem_done completes the outstanding request. For a load (mem_we = 0), resp_valid goes high in the same cycle, one-hot on the issuing core, with resp_rd set to the destination register and resp_data = mem_rdata. A store produces no response.
- R9: A push of a load whose destination register matches a pending load in the same buffer discards the older load. Only the newer one is issued.
- R10: A push of a store whose address matches a pending store in the same buffer discards the older store, but only when that buffer holds no pending load to the same address. Otherwise all of them are issued in order.
- R11: After reset, mem_valid is low, all push_ready bits are high and resp_valid is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | NCORE | Per-core push strobe |
| push_ready | output | NCORE | Per-core buffer not full |
| push_we | input | NCORE | Per-core request kind, 1 = store |
| push_addr | input | NCORE*ADDR_W | Per-core byte address, core c at bits c*ADDR_W |
| push_data | input | NCORE*DATA_W | Per-core store data |
| push_rd | input | NCORE*REG_W | Per-core load destination register |
| prio | input | NCORE | Per-core priority-load flag |
| mem_valid | output | 1 | Request offered to DRAM |
| mem_ready | input | 1 | DRAM accepts a request |
| mem_we | output | 1 | Offered request is a store |
| mem_addr | output | ADDR_W | Offered address |
| mem_wdata | output | DATA_W | Offered store data |
| mem_core | output | CID_W | Core that owns the offered request |
| mem_done | input | 1 | Outstanding request completed |
| mem_rdata | input | DATA_W | Load data with mem_done |
| resp_valid | output | NCORE | One-hot load response strobe |
| resp_data | output | DATA_W | Load response data |
| resp_rd | output | REG_W | Load response destination register |

## Verification
A scoreboard predicts the exact order of DRAM issues for several loadings:
- A single busy core tells a cap-triggered re-selection apart from a stall.
- Three cores with unequal work separate rotating order from fixed order.
- A raised priority flag must pull its core ahead of the rotation.
- A row change inside one core must hand over to another core.

Buffers filled with duplicate loads and stores check which requests are collapsed and which survive behind a load to the same address. A full buffer with a refused extra push checks the back-pressure. Two cores that push in the same cycle from idle show that the idle choice starts after the last core served.

// File: rtl/rsched_pkg.sv
package rsched_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int REG_W  = 5;
    localparam int COL_W  = 10;
    localparam int ROW_W  = ADDR_W - COL_W;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [REG_W-1:0]  rd;
    } req_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SERVE, ST_SWITCH, ST_WAIT} st_e;
endpackage

// File: rtl/rsched_pick.sv
// Rotating search: the first set bit at or after 'start', wrapping around.
module rsched_pick #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            int j;
            j = int'(start) + i;
            if (j >= N) j = j - N;
            if (req[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/rsched_buf.sv
// Per-core request buffer with in-place collapsing of superseded requests.
module rsched_buf
    import rsched_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  req_t push_req,
    output logic ready,
    input  logic pop,
    output req_t head,
    output logic head_live,
    output logic empty
);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    typedef struct packed {
        req_t [DEPTH-1:0] mem;
        logic [DEPTH-1:0] live;
        logic [PW-1:0]    rp;
        logic [PW-1:0]    wp;
        logic [CW-1:0]    cnt;
    } bst_t;

    bst_t s_d, s_q;
    logic do_push, do_pop, ld_hit;

    always_comb begin
        s_d     = s_q;
        ready   = (s_q.cnt != FULLV);
        empty   = (s_q.cnt == '0);
        do_push = push && ready;
        do_pop  = pop && !empty;
        ld_hit  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (s_q.live[i] && !s_q.mem[i].we && s_q.mem[i].addr == push_req.addr)
                ld_hit = 1'b1;
        end
        if (do_push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (s_q.live[i] && !push_req.we && !s_q.mem[i].we &&
                    s_q.mem[i].rd == push_req.rd)
                    s_d.live[i] = 1'b0;
                if (s_q.live[i] && push_req.we && s_q.mem[i].we &&
                    s_q.mem[i].addr == push_req.addr && !ld_hit)
                    s_d.live[i] = 1'b0;
            end
        end
        if (do_pop) begin
            s_d.live[s_q.rp] = 1'b0;
            s_d.rp = (s_q.rp == PW'(DEPTH - 1)) ? '0 : s_q.rp + PW'(1);
        end
        if (do_push) begin
            s_d.mem[s_q.wp]  = push_req;
            s_d.live[s_q.wp] = 1'b1;
            s_d.wp = (s_q.wp == PW'(DEPTH - 1)) ? '0 : s_q.wp + PW'(1);
        end
        s_d.cnt   = s_q.cnt + CW'(do_push) - CW'(do_pop);
        head      = s_q.mem[s_q.rp];
        head_live = s_q.live[s_q.rp] && !empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rsched_top.sv
module rsched_top
    import rsched_pkg::*;
#(
    parameter int NCORE     = 16,
    parameter int DEPTH     = 32,
    parameter int ROW_DELAY = 10,
    parameter int COL_DELAY = 2,
    localparam int CID_W    = (NCORE > 1) ? $clog2(NCORE) : 1,
    localparam int MAX_RUN  = (ROW_DELAY / COL_DELAY < 1) ? 1 : ROW_DELAY / COL_DELAY,
    localparam int RUN_W    = $clog2(MAX_RUN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORE-1:0]        push_valid,
    output logic [NCORE-1:0]        push_ready,
    input  logic [NCORE-1:0]        push_we,
    input  logic [NCORE*ADDR_W-1:0] push_addr,
    input  logic [NCORE*DATA_W-1:0] push_data,
    input  logic [NCORE*REG_W-1:0]  push_rd,
    input  logic [NCORE-1:0]        prio,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic [CID_W-1:0]        mem_core,
    input  logic                    mem_done,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [NCORE-1:0]        resp_valid,
    output logic [DATA_W-1:0]       resp_data,
    output logic [REG_W-1:0]        resp_rd
);
    typedef struct packed {
        st_e              st;
        logic [CID_W-1:0] core;
        logic [ROW_W-1:0] row;
        logic [RUN_W-1:0] run;
        logic             fly_we;
        logic [REG_W-1:0] fly_rd;
        logic [CID_W-1:0] fly_core;
    } sch_t;

    sch_t s_d, s_q;

    req_t             buf_head [NCORE];
    logic [NCORE-1:0] buf_live, buf_empty, buf_pop;
    logic [CID_W-1:0] start, pri_idx, pen_idx, pick_idx;
    logic             pri_found, pen_found;
    req_t             hd;

    for (genvar g = 0; g < NCORE; g++) begin : g_buf
        req_t preq;
        assign preq.we   = push_we[g];
        assign preq.addr = push_addr[g*ADDR_W +: ADDR_W];
        assign preq.data = push_data[g*DATA_W +: DATA_W];
        assign preq.rd   = push_rd[g*REG_W +: REG_W];
        rsched_buf #(.DEPTH(DEPTH)) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_valid[g]),
            .push_req (preq),
            .ready    (push_ready[g]),
            .pop      (buf_pop[g]),
            .head     (buf_head[g]),
            .head_live(buf_live[g]),
            .empty    (buf_empty[g])
        );
    end

    assign start = (s_q.core == CID_W'(NCORE - 1)) ? '0 : s_q.core + CID_W'(1);

    rsched_pick #(.N(NCORE)) u_pick_pri (
        .req(prio & ~buf_empty), .start(start), .found(pri_found), .idx(pri_idx)
    );
    rsched_pick #(.N(NCORE)) u_pick_pen (
        .req(~buf_empty), .start(start), .found(pen_found), .idx(pen_idx)
    );

    assign pick_idx = pri_found ? pri_idx : pen_idx;

    always_comb begin
        s_d       = s_q;
        buf_pop   = '0;
        mem_valid = 1'b0;
        hd        = buf_head[s_q.core];
        case (s_q.st)
            ST_IDLE, ST_SWITCH: begin
                if (pen_found) begin
                    s_d.core = pick_idx;
                    s_d.row  = buf_head[pick_idx].addr[ADDR_W-1:COL_W];
                    s_d.run  = '0;
                    s_d.st   = ST_SERVE;
                end else begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_SERVE: begin
                if (buf_empty[s_q.core]) begin
                    s_d.st = ST_SWITCH;
                end else if (!buf_live[s_q.core]) begin
                    buf_pop[s_q.core] = 1'b1;
                end else if (hd.addr[ADDR_W-1:COL_W] != s_q.row ||
                             s_q.run >= RUN_W'(MAX_RUN)) begin
                    s_d.st = ST_SWITCH;
                end else begin
                    mem_valid = 1'b1;
                    if (mem_ready) begin
                        buf_pop[s_q.core] = 1'b1;
                        s_d.run      = s_q.run + RUN_W'(1);
                        s_d.fly_we   = hd.we;
                        s_d.fly_rd   = hd.rd;
                        s_d.fly_core = s_q.core;
                        s_d.st       = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_done) s_d.st = ST_SERVE;
            end
            default: s_d.st = ST_IDLE;
        endcase
        mem_we     = hd.we;
        mem_addr   = hd.addr;
        mem_wdata  = hd.data;
        mem_core   = s_q.core;
        resp_valid = (s_q.st == ST_WAIT && mem_done && !s_q.fly_we) ?
                     (NCORE'(1) << s_q.fly_core) : '0;
        resp_data  = mem_rdata;
        resp_rd    = s_q.fly_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.core <= CID_W'(NCORE - 1);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/rsched_chk.sv
module rsched_chk
    import rsched_pkg::*;
#(
    parameter int NCORE   = 16,
    parameter int MAX_RUN = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic             mem_done,
    input logic [ROW_W-1:0] mem_row,
    input logic [NCORE-1:0] resp_valid,
    input st_e              st
);
    logic             fire, busy_q;
    int               run_q;
    logic [ROW_W-1:0] row_q;

    assign fire = mem_valid && mem_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            run_q  <= 0;
            row_q  <= '0;
        end else begin
            if (fire) busy_q <= 1'b1;
            else if (mem_done) busy_q <= 1'b0;
            if (st == ST_IDLE || st == ST_SWITCH) run_q <= 0;
            else if (fire) run_q <= run_q + 1;
            if (fire) row_q <= mem_row;
        end
    end

    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !mem_valid); // R7
    AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (run_q < MAX_RUN)); // R4
    AST_SAME_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && run_q != 0) |-> (mem_row == row_q)); // R3
    AST_RESP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp_valid)); // R8
    AST_RESP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid != '0) |-> (mem_done && busy_q)); // R8
endmodule

bind rsched_top rsched_chk #(.NCORE(NCORE), .MAX_RUN(MAX_RUN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_done  (mem_done),
    .mem_row   (mem_addr[rsched_pkg::ADDR_W-1:rsched_pkg::COL_W]),
    .resp_valid(resp_valid),
    .st        (s_q.st)
);

// File: tb/tb_rsched_top.sv
module tb_rsched_top;
    import rsched_pkg::*;

    localparam int NC  = 4;
    localparam int CIW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NC-1:0]        push_valid = '0, push_we = '0, prio = '0;
    logic [NC-1:0]        push_ready, resp_valid;
    logic [NC*ADDR_W-1:0] push_addr = '0;
    logic [NC*DATA_W-1:0] push_data = '0;
    logic [NC*REG_W-1:0]  push_rd = '0;
    logic                 mem_ready = 1'b0;
    logic                 mem_valid, mem_we;
    logic                 mem_done;
    logic [ADDR_W-1:0]    mem_addr, lat_addr;
    logic [DATA_W-1:0]    mem_wdata, mem_rdata, resp_data;
    logic [REG_W-1:0]     resp_rd;
    logic [CIW-1:0]       mem_core;
    int                   lat;

    rsched_top #(.NCORE(NC), .DEPTH(4), .ROW_DELAY(4), .COL_DELAY(2)) dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
        .push_we(push_we), .push_addr(push_addr), .push_data(push_data),
        .push_rd(push_rd), .prio(prio), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_core(mem_core), .mem_done(mem_done), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_rd(resp_rd)
    );

    function automatic logic [DATA_W-1:0] rd_val(input logic [ADDR_W-1:0] a);
        return DATA_W'(a) ^ 32'hC3C3_0000;
    endfunction

    function automatic logic [ADDR_W-1:0] ad(input int row, input int col);
        return {ROW_W'(row), COL_W'(col)};
    endfunction

    // DRAM model: completes each accepted request three cycles later.
    assign mem_rdata = rd_val(lat_addr);
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat <= 0; lat_addr <= '0; mem_done <= 1'b0;
        end else begin
            mem_done <= 1'b0;
            if (mem_valid && mem_ready) begin
                lat <= 3; lat_addr <= mem_addr;
            end else if (lat != 0) begin
                lat <= lat - 1;
                if (lat == 1) mem_done <= 1'b1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    string tag = "R11 reset";
    logic [63:0] exp_iss[$];
    logic [63:0] exp_rsp[$];

    task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic e_iss(input int c, input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        exp_iss.push_back(64'({CIW'(c), we, a, (we ? d : '0)}));
    endtask

    task automatic e_ld(input int c, input logic [ADDR_W-1:0] a, input int r);
        e_iss(c, 1'b0, a, '0);
        exp_rsp.push_back(64'({CIW'(c), REG_W'(r), rd_val(a)}));
    endtask

    task automatic push_set(input int c, input bit we, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d, input int r);
        push_valid[c] = 1'b1;
        push_we[c]    = we;
        push_addr[c*ADDR_W +: ADDR_W] = a;
        push_data[c*DATA_W +: DATA_W] = d;
        push_rd[c*REG_W +: REG_W]     = REG_W'(r);
    endtask

    task automatic push_go();
        @(posedge clk); #1;
        push_valid = '0;
    endtask

    task automatic ld(input int c, input logic [ADDR_W-1:0] a, input int r);
        push_set(c, 1'b0, a, '0, r); push_go();
    endtask

    task automatic sto(input int c, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        push_set(c, 1'b1, a, d, 0); push_go();
    endtask

    task automatic drain();
        int n;
        n = 0;
        mem_ready = 1'b1;
        while ((exp_iss.size() != 0 || exp_rsp.size() != 0) && n < 300) begin
            @(posedge clk); n++;
        end
        repeat (8) @(posedge clk);
        #1 mem_ready = 1'b0;
        chk(exp_iss.size() == 0 && exp_rsp.size() == 0, {tag, " all expected items seen"},
            64'(exp_iss.size() + exp_rsp.size()), 64'd0);
        @(negedge clk);
        chk(mem_valid == 1'b0, "R7 no request offered once drained", 64'(mem_valid), 64'd0);
        @(posedge clk); #1;
    endtask

    // Monitor: compares issues and responses against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_valid && mem_ready) begin
                logic [63:0] act, e;
                act = 64'({mem_core, mem_we, mem_addr, (mem_we ? mem_wdata : '0)});
                if (exp_iss.size() == 0) chk(1'b0, {tag, " unexpected issue"}, act, 64'd0);
                else begin
                    e = exp_iss.pop_front();
                    chk(act == e, {tag, " issue order"}, act, e);
                end
            end
            if (resp_valid != '0) begin
                logic [63:0] act, e;
                int idx;
                idx = 0;
                for (int i = 0; i < NC; i++) if (resp_valid[i]) idx = i;
                act = 64'({CIW'(idx), resp_rd, resp_data});
                if (exp_rsp.size() == 0) chk(1'b0, {tag, " R8 unexpected response"}, act, 64'd0);
                else begin
                    e = exp_rsp.pop_front();
                    chk(act == e, {tag, " R8 response"}, act, e);
                end
            end
        end
    end

    bit finished = 1'b0;

    initial begin
        repeat (1000000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired in %s actual=running expected=done", tag);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(mem_valid == 1'b0, "R11 mem_valid after reset", 64'(mem_valid), 64'd0);
        chk(push_ready == 4'hF, "R11 push_ready after reset", 64'(push_ready), 64'hF);
        chk(resp_valid == '0, "R11 resp_valid after reset", 64'(resp_valid), 64'd0);
        @(posedge clk); #1;

        // One core, three same-row loads, cap of two: re-selects the same core.
        tag = "R4 cap reselects lone core";
        e_ld(0, ad(1, 0), 1); e_ld(0, ad(1, 4), 2); e_ld(0, ad(1, 8), 3);
        ld(0, ad(1, 0), 1); ld(0, ad(1, 4), 2); ld(0, ad(1, 8), 3);
        drain();

        // Rotation after the cap: c1,c1 then c2, c3, back to c1.
        tag = "R5 R3 rotating switch";
        e_ld(1, ad(2, 0), 1); e_ld(1, ad(2, 4), 2); e_ld(2, ad(3, 0), 4);
        e_ld(3, ad(4, 0), 5); e_ld(1, ad(2, 8), 3);
        ld(1, ad(2, 0), 1); ld(1, ad(2, 4), 2); ld(1, ad(2, 8), 3);
        ld(2, ad(3, 0), 4); ld(3, ad(4, 0), 5);
        drain();

        // Priority core 3 beats core 1 at the switch after the cap.
        tag = "R5 priority first";
        prio = 4'b1000;
        e_ld(0, ad(5, 0), 1); e_ld(0, ad(5, 4), 2); e_ld(3, ad(7, 0), 5);
        e_ld(0, ad(5, 8), 3); e_ld(1, ad(6, 0), 4);
        ld(0, ad(5, 0), 1); ld(0, ad(5, 4), 2); ld(0, ad(5, 8), 3);
        ld(1, ad(6, 0), 4); ld(3, ad(7, 0), 5);
        drain();
        prio = '0;

        // A row change at the head hands over to core 2.
        tag = "R6 row change forces switch";
        e_ld(1, ad(8, 0), 1); e_ld(2, ad(10, 0), 3); e_ld(1, ad(9, 0), 2);
        ld(1, ad(8, 0), 1); ld(1, ad(9, 0), 2); ld(2, ad(10, 0), 3);
        drain();

        // Older load to the same register and older store to the same address drop.
        tag = "R9 R10 collapse";
        e_ld(0, ad(11, 4), 3); e_iss(0, 1'b1, ad(11, 8), 32'h2222);
        ld(0, ad(11, 0), 3); ld(0, ad(11, 4), 3);
        sto(0, ad(11, 8), 32'h1111); sto(0, ad(11, 8), 32'h2222);
        drain();

        // A load to the address sits between the stores: nothing is dropped.
        tag = "R10 store kept behind load";
        e_iss(0, 1'b1, ad(12, 0), 32'hAAAA); e_ld(0, ad(12, 0), 4);
        e_iss(0, 1'b1, ad(12, 0), 32'hBBBB);
        sto(0, ad(12, 0), 32'hAAAA); ld(0, ad(12, 0), 4); sto(0, ad(12, 0), 32'hBBBB);
        drain();

        // Full buffer refuses a fifth push.
        tag = "R1 full buffer";
        e_ld(2, ad(13, 0), 1); e_ld(2, ad(13, 4), 2); e_ld(2, ad(13, 8), 3); e_ld(2, ad(13, 12), 4);
        ld(2, ad(13, 0), 1); ld(2, ad(13, 4), 2); ld(2, ad(13, 8), 3); ld(2, ad(13, 12), 4);
        @(negedge clk);
        chk(push_ready[2] == 1'b0, "R1 push_ready low when full", 64'(push_ready[2]), 64'd0);
        chk(mem_valid == 1'b1, "R7 request held while mem_ready low", 64'(mem_valid), 64'd1);
        @(posedge clk); #1;
        ld(2, ad(13, 16), 5);
        drain();
        chk(push_ready == 4'hF, "R1 push_ready back after drain", 64'(push_ready), 64'hF);

        // Two cores push together from idle: search starts after last core (2).
        tag = "R2 idle rotation";
        e_ld(3, ad(15, 0), 2); e_ld(1, ad(14, 0), 1);
        push_set(1, 1'b0, ad(14, 0), '0, 1); push_set(3, 1'b0, ad(15, 0), '0, 2); push_go();
        drain();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule